// File: doc/BRIEF.md
# Frame-to-Chunk Transmit Framer

This block turns Ethernet frames, offered one byte at a time with an end marker on the last byte, into a stream of fixed-size transmit chunks for a serial host link. Each chunk is a 4-byte header sent most significant byte first, followed by a 64-byte payload. The header marks the chunk as data and says whether the payload carries frame bytes, whether a frame begins in it, and whether a frame ends in it and at which byte. A single odd parity bit protects the header.

A burst starts with a one-cycle `start_i` pulse. On that pulse the block latches three values: the transmit credit count, the number of receive chunks the peer has waiting, and an interrupt flag. It sends as many data chunks as credits allow. When the peer has more receive chunks waiting than there are data chunks, it adds empty chunks until the totals match. When an interrupt is flagged and the burst would otherwise carry nothing, it sends a single empty chunk. A frame that runs out of credit continues in the next burst. The payload of a chunk is held in a one-chunk buffer, because the end flags in the header are only known once that payload has been collected.

Top module: `chunk_framer`

## Requirements
- R1: Every chunk starts with a 32-bit header sent most significant byte first. In that header bit 31 is 1, bit 21 means payload carries frame data, bit 20 means a frame starts here, bits 19:16 are a start word offset, bit 14 means a frame ends here, bits 13:8 are the end byte index, bits 30:22, 15 and 7:1 are 0, and bit 0 makes the count of ones in the word odd. `out_first_o` is high on the first header byte only.
- R2: Bit 20 is 1 only on the chunk that carries the first byte of a frame, and the start word offset is always 0.
- R3: Bit 14 is 1 only on the chunk that carries the last byte of a frame. Bits 13:8 then hold that byte's index in the payload; otherwise they are 0.
- R4: A data chunk's payload carries the frame bytes in arrival order, and the bytes after a frame's last byte are 0. An empty chunk's payload is all 0.
- R5: A burst carries at most min(credit, 48) data chunks. A frame not finished within them continues in the next burst, with bit 20 clear.
- R6: A burst carries max(data chunks, min(pending, 48)) chunks in total. Empty chunks (header 0x80000000) come after all data chunks.
- R7: With the interrupt flag set and no data or pending chunks, a burst carries exactly one empty chunk. In any other case the flag has no effect.
- R8: `in_ready_o` is high only while a chunk payload is being collected. With zero credit, no frame byte is consumed.
- R9: `busy_o` rises the cycle after an accepted start and falls after the burst's last byte. A start pulse during a burst is ignored, and a burst with nothing to send ends with no output.
- R10: While `out_ready_i` is low, `out_valid_o` and `out_data_o` hold.
- R11: After reset, `busy_o`, `out_valid_o` and `in_ready_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a burst (accepted when idle) |
| credit_i | input | CNT_W | Transmit credits for the burst |
| pend_i | input | CNT_W | Receive chunks waiting at the peer |
| irq_i | input | 1 | Interrupt flag for the burst |
| in_valid_i | input | 1 | Frame byte valid |
| in_data_i | input | 8 | Frame byte |
| in_last_i | input | 1 | Byte is the last of its frame |
| in_ready_o | output | 1 | Frame byte accepted |
| out_valid_o | output | 1 | Chunk byte valid |
| out_data_o | output | 8 | Chunk byte |
| out_first_o | output | 1 | First header byte of a chunk |
| out_ready_i | input | 1 | Chunk byte taken |
| busy_o | output | 1 | Burst in progress |

## Verification
A wrong frame-position flag shows up at once: start-valid or end-valid appears in the wrong header, or the parity bit is wrong, within four bytes of the chunk start. Wrong credit or padding counts change the number of chunks in the burst and become visible when `busy_o` falls. A stale payload buffer or a wrong byte mask corrupts the payload bytes of the affected chunk. A lost continuation flag sets start-valid again on the first chunk of the next burst.

// File: rtl/chunk_framer.sv
`timescale 1ns/1ps
module chunk_framer #(
  parameter int PAY_BYTES = 64,
  parameter int MAX_BURST = 48,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] credit_i,
  input  logic [CNT_W-1:0] pend_i,
  input  logic             irq_i,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  input  logic             in_last_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  output logic             out_first_o,
  input  logic             out_ready_i,
  output logic             busy_o
);
  localparam int OFF_W = $clog2(PAY_BYTES);
  localparam int BC_W  = $clog2(MAX_BURST + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEC, S_FILL, S_HDR, S_PAY} st_t;
  st_t state;

  logic [BC_W-1:0]  cred_q, pend_q, dcnt_q, tcnt_q;
  logic             irq_q, pad_q, mid_q;
  logic             dv_q, sv_q, ev_q;
  logic [OFF_W-1:0] off_q, idx_q;
  logic [1:0]       hb_q;
  logic [7:0]       buf_q [PAY_BYTES];

  function automatic logic [BC_W-1:0] clampc(input logic [CNT_W-1:0] v);
    return (int'(v) > MAX_BURST) ? BC_W'(MAX_BURST) : BC_W'(v);
  endfunction

  logic [31:0] hdr_w;
  logic [30:0] hdr_hi;
  assign hdr_hi = {9'b0, dv_q, sv_q, 4'b0, 1'b0, ev_q, 6'(off_q), 7'b0};
  assign hdr_w  = {1'b1, hdr_hi[29:0], ~^{1'b1, hdr_hi[29:0]}};

  logic take_data, take_pad, fill_end, keep;
  assign take_data = !pad_q && (dcnt_q < cred_q) && (mid_q || in_valid_i);
  assign take_pad  = (tcnt_q < pend_q) || (tcnt_q == '0 && irq_q);
  assign fill_end  = in_last_i || (idx_q == OFF_W'(PAY_BYTES - 1));
  assign keep      = dv_q && (!ev_q || idx_q <= off_q);

  assign busy_o      = state != S_IDLE;
  assign in_ready_o  = state == S_FILL;
  assign out_valid_o = (state == S_HDR) || (state == S_PAY);
  assign out_first_o = (state == S_HDR) && (hb_q == 2'd0);

  always_comb begin
    out_data_o = 8'h00;
    if (state == S_HDR) out_data_o = hdr_w[{~hb_q, 3'b000} +: 8];
    else if (state == S_PAY && keep) out_data_o = buf_q[idx_q];
  end

  always_ff @(posedge clk) begin
    if (state == S_FILL && in_valid_i) buf_q[idx_q] <= in_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cred_q <= '0;
      pend_q <= '0;
      dcnt_q <= '0;
      tcnt_q <= '0;
      irq_q  <= 1'b0;
      pad_q  <= 1'b0;
      mid_q  <= 1'b0;
      dv_q   <= 1'b0;
      sv_q   <= 1'b0;
      ev_q   <= 1'b0;
      off_q  <= '0;
      idx_q  <= '0;
      hb_q   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start_i) begin
          cred_q <= clampc(credit_i);
          pend_q <= clampc(pend_i);
          irq_q  <= irq_i;
          dcnt_q <= '0;
          tcnt_q <= '0;
          pad_q  <= 1'b0;
          state  <= S_DEC;
        end
        S_DEC: begin
          ev_q  <= 1'b0;
          off_q <= '0;
          idx_q <= '0;
          hb_q  <= '0;
          if (take_data) begin
            dv_q  <= 1'b1;
            sv_q  <= !mid_q;
            state <= S_FILL;
          end else if (take_pad) begin
            dv_q  <= 1'b0;
            sv_q  <= 1'b0;
            pad_q <= 1'b1;
            state <= S_HDR;
          end else begin
            state <= S_IDLE;
          end
        end
        S_FILL: if (in_valid_i) begin
          if (fill_end) begin
            ev_q  <= in_last_i;
            off_q <= in_last_i ? idx_q : '0;
            mid_q <= !in_last_i;
            state <= S_HDR;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        S_HDR: if (out_ready_i) begin
          if (hb_q == 2'd3) begin
            idx_q <= '0;
            state <= S_PAY;
          end
          hb_q <= hb_q + 1'b1;
        end
        S_PAY: if (out_ready_i) begin
          if (idx_q == OFF_W'(PAY_BYTES - 1)) begin
            dcnt_q <= dcnt_q + BC_W'(dv_q);
            tcnt_q <= tcnt_q + 1'b1;
            state  <= S_DEC;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chunk_framer_chk.sv
`timescale 1ns/1ps
module chunk_framer_chk #(
  parameter int PAY_BYTES = 64,
  parameter int MAX_BURST = 48,
  parameter int CNT_W     = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [CNT_W-1:0] credit_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic [7:0]       out_data_o,
  input logic             out_first_o,
  input logic             out_ready_i,
  input logic             busy_o
);
  logic [15:0] pos_c, ccnt_c, dcnt_c, cred_c;
  logic hs;
  assign hs = out_valid_o && out_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_c <= '0; ccnt_c <= '0; dcnt_c <= '0; cred_c <= '0;
    end else begin
      if (start_i && !busy_o) begin
        ccnt_c <= '0;
        dcnt_c <= '0;
        cred_c <= (int'(credit_i) > MAX_BURST) ? 16'(MAX_BURST) : 16'(credit_i);
      end else if (hs) begin
        if (out_first_o) ccnt_c <= ccnt_c + 1'b1;
        if (pos_c == 16'd1 && out_data_o[5]) dcnt_c <= dcnt_c + 1'b1;
      end
      if (hs) pos_c <= out_first_o ? 16'd1 : pos_c + 1'b1;
    end
  end

  AST_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && out_first_o |-> out_data_o == 8'h80); // R1
  AST_SWO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hs && pos_c == 16'd1 && !out_first_o |-> out_data_o[3:0] == 4'h0); // R2
  AST_CREDIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> dcnt_c <= cred_c); // R5
  AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ccnt_c <= 16'(MAX_BURST)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !in_ready_o && !out_valid_o); // R8
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)); // R10
endmodule

bind chunk_framer chunk_framer_chk #(.PAY_BYTES(PAY_BYTES), .MAX_BURST(MAX_BURST), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .credit_i(credit_i),
  .in_ready_o(in_ready_o), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
  .out_first_o(out_first_o), .out_ready_i(out_ready_i), .busy_o(busy_o)
);

// File: tb/chunk_framer_tb_top.sv
`timescale 1ns/1ps
module chunk_framer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, irq = 1'b0;
  logic [7:0] credit = '0, pend = '0, in_data = '0, out_data;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid, out_first, busy;

  always #2.5 clk = ~clk;

  chunk_framer dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .credit_i(credit), .pend_i(pend),
    .irq_i(irq), .in_valid_i(in_valid), .in_data_i(in_data), .in_last_i(in_last),
    .in_ready_o(in_ready), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_first_o(out_first), .out_ready_i(out_ready), .busy_o(busy)
  );

  int tests = 0, fails = 0;
  int fr_len = 0, fr_idx = 0, fr_base = 0, m_pos = 0, cyc = 0;
  logic stall_en = 1'b0, hs_q = 1'b0;
  logic [7:0] cap [16384];
  int ncap = 0;

  // cred[39:32] pend[31:24] irq[23:20] stall[19:16] frame length[15:0]
  localparam logic [39:0] VEC [13] = '{
    40'h03_00_0_0_003C, 40'h03_00_0_0_0040, 40'h03_00_0_0_0041,
    40'h02_05_0_1_0064, 40'h00_02_0_0_0000, 40'h00_00_1_0_0000,
    40'h05_00_1_0_000A, 40'h00_00_0_0_0000, 40'h01_00_0_0_0096,
    40'h3C_00_0_0_0C1C, 40'h04_3C_0_0_000A, 40'h00_03_1_0_0000,
    40'h02_01_0_1_0001
  };

  function automatic logic [7:0] fbyte(input int i);
    return 8'((fr_base + i * 7) & 255);
  endfunction

  function automatic logic [31:0] hdr_exp(input bit dv, input bit sv, input bit ev, input int off);
    logic [31:0] w;
    w = 32'h8000_0000 | (32'(dv) << 21) | (32'(sv) << 20) | (32'(ev) << 14) | (32'(off) << 8);
    w[0] = ~^w[31:1];
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    hs_q <= in_valid && in_ready;
    if (out_valid && out_ready) begin
      cap[ncap] <= out_data;
      ncap <= ncap + 1;
    end
  end

  initial forever begin
    @(negedge clk);
    if (hs_q) fr_idx++;
    in_valid  = fr_idx < fr_len;
    in_data   = fbyte(fr_idx);
    in_last   = fr_idx == fr_len - 1;
    out_ready = !(stall_en && (cyc % 3 == 0));
    cyc++;
  end

  task automatic load_frame(input int len, input int base);
    @(negedge clk);
    fr_base = base; fr_len = len; fr_idx = 0; m_pos = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_burst(input int cr, input int pd, input bit iq, input bit st, input bit restart);
    int base, n, cl, pl, dc, tot, rem, nb, first;
    bit sv, ev;
    logic [31:0] h;
    base = ncap;
    stall_en = st;
    @(negedge clk);
    start = 1'b1; credit = 8'(cr); pend = 8'(pd); irq = iq;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R9", "busy after start", longint'(busy), 1);
    if (restart) begin
      repeat (20) @(negedge clk);
      start = 1'b1; pend = 8'd10; credit = 8'd5;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    stall_en = 1'b0;
    n = ncap - base;
    rem = fr_len - m_pos;
    cl = cr > 48 ? 48 : cr;
    pl = pd > 48 ? 48 : pd;
    dc = (rem + 63) / 64;
    if (dc > cl) dc = cl;
    tot = dc > pl ? dc : pl;
    if (tot == 0 && iq) tot = 1;
    check(n == tot * 68, "R5/R6/R7/R9", "bytes in burst", n, tot * 68);
    for (int c = 0; c < tot && (c + 1) * 68 <= n; c++) begin
      int b = base + c * 68;
      h = {cap[b], cap[b+1], cap[b+2], cap[b+3]};
      if (c < dc) begin
        nb = rem > 64 ? 64 : rem;
        sv = m_pos == 0;
        ev = nb == rem;
        check(h == hdr_exp(1, sv, ev, ev ? nb - 1 : 0), "R1/R2/R3", "data header", h, hdr_exp(1, sv, ev, ev ? nb - 1 : 0));
      end else begin
        nb = 0;
        check(h == 32'h8000_0000, "R6/R7", "empty header", h, 32'h8000_0000);
      end
      first = -1;
      for (int j = 0; j < 64; j++)
        if (first < 0 && cap[b+4+j] !== (j < nb ? fbyte(m_pos + j) : 8'h00)) first = j;
      check(first < 0, "R4", "payload byte", first < 0 ? 0 : cap[b+4+first],
            first < 0 ? 0 : (first < nb ? fbyte(m_pos + first) : 0));
      m_pos += nb; rem -= nb;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !out_valid && !in_ready, "R11", "reset outputs", {busy, out_valid, in_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !out_valid && !in_ready, "R11", "idle outputs", {busy, out_valid, in_ready}, 0);

    for (int v = 0; v < 13; v++) begin
      load_frame(int'(VEC[v][15:0]), v * 13 + 5);
      for (int k = 0; k < 8; k++) begin
        run_burst(int'(VEC[v][39:32]), int'(VEC[v][31:24]), VEC[v][20], VEC[v][16], 1'b0);
        if (m_pos >= fr_len) break;
      end
    end

    // R9: a second start during a burst must not change its length
    load_frame(0, 1);
    run_burst(0, 4, 1'b0, 1'b0, 1'b1);

    // R8: zero credit leaves the offered frame untouched
    load_frame(10, 99);
    run_burst(0, 1, 1'b0, 1'b0, 1'b0);
    check(fr_idx == 0, "R8", "bytes consumed at zero credit", fr_idx, 0);
    run_burst(1, 0, 1'b0, 1'b0, 1'b0);
    check(fr_idx == 10, "R8", "bytes consumed with credit", fr_idx, 10);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule